// File: doc/BRIEF.md
# Flash Word Program and Sector Erase Sequencer

This block sits on the host side of a parallel NOR flash. It takes one request at a time: either write one word at an address, or clear one sector. It turns the request into the unlock-and-command write cycles the flash expects, and issues them on a simple single-cycle write/read bus. It then polls the target address until the toggling status bit stops. Finally it checks the word it read back and reports the result with a one-cycle `done` pulse and a `fail` flag.

A read issued on the bus (`bus_rd` high for one cycle) must return its data on `bus_rdata` in the following cycle. The poll spacing and the two time limits are parameters counted in clock cycles. The defaults are a 4-cycle gap, 8000 cycles for a word write (32 us at 250 MHz) and 8,000,000 cycles for a sector erase (32 ms). A failed check is not trusted straight away: the engine reads the location twice more and reports failure only if both of those reads are also wrong.

Top module: `flash_prog_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle `req_ready` stays low until `done`, so requests presented while busy start nothing.
- R2: A word write issues exactly four bus writes, in this order: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the request data at the request address. Commands sit in the low 8 data bits, with the upper bits zero.
- R3: A sector erase issues exactly six bus writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x50 at the request address.
- R4: Status reads start only after the last write. The first read comes POLL_GAP+1 cycles after the final write cycle. Successive poll reads are POLL_GAP+2 cycles apart. A read and a write never share a cycle.
- R5: The operation counts as finished when two consecutive poll reads carry the same value in data bit 6 (STAT_BIT). The second of those reads is the word that gets checked.
- R6: The checked word is compared with the expected value: the request data for a write, all ones for an erase. If it matches, the result is success (`fail`=0).
- R7: On a mismatch, the engine performs two more reads of the address. `fail`=1 only if both mismatch. If either matches, the result is success.
- R8: If polling has not ended when the limit expires, the result is `fail`=1. The limit is PROG_TMO cycles for a word write and ERASE_TMO cycles for an erase, counted from acceptance.
- R9: `done` is a single-cycle pulse coinciding with the return of `req_ready`. `fail` is valid from that cycle until the next result.
- R10: After reset, `req_ready`=1, `done`=0, `fail`=0 and the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_erase | input | 1 | 1 = sector erase, 0 = word write |
| req_addr | input | ADDR_W | Word address, or sector address for an erase |
| req_data | input | DATA_W | Word to write (ignored for an erase) |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last operation, 1 = failed |
| bus_wr | output | 1 | Bus write strobe, one cycle per write |
| bus_rd | output | 1 | Bus read strobe, data returned next cycle |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid the cycle after `bus_rd` |

## Verification
A flash model in the bench toggles bit 6 for a chosen number of reads. After that it returns a chosen number of wrong words (the good value with bit 0 flipped) before it settles on the good word.

Random write and erase requests vary the busy length and the number of wrong words. This separates three cases:
- a check that passes at once;
- a mismatch rescued by either reread;
- a true failure when both rereads stay wrong.

A busy flash that never settles exposes the timeout. A busy length that lies between the two limits shows whether the right limit is chosen for each kind of operation. Holding `req_valid` high during an operation shows that back-pressure works. The model's cycle stamps check the write-to-read spacing.

// File: rtl/flash_eng_pkg.sv
// Shared state encoding and flash command constants for the program engine.
package flash_eng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WRITE, ST_GAP, ST_POLL_RD, ST_POLL_CAP, ST_VER_RD, ST_VER_CAP
    } eng_state_t;

    localparam logic [11:0] UNLOCK_A1 = 12'h555;
    localparam logic [11:0] UNLOCK_A2 = 12'h2AA;
    localparam logic [7:0]  KEY_FIRST  = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  CMD_WORD   = 8'hA0;
    localparam logic [7:0]  CMD_ESETUP = 8'h80;
    localparam logic [7:0]  CMD_SECTOR = 8'h50;
endpackage

// File: rtl/flash_cmd_seq.sv
// Command cycle generator: maps a cycle index and the operation kind to the
// address/data of that bus write. Assumes idx stays within the sequence length.
module flash_cmd_seq
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [2:0]        idx,
    input  logic              erase,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_data,
    output logic              cyc_last
);
    // Select the address/data pair of the current write cycle.
    always_comb begin
        cyc_addr = ADDR_W'(UNLOCK_A1);
        cyc_data = DATA_W'(KEY_FIRST);
        case (idx)
            3'd0: ;
            3'd1: begin
                cyc_addr = ADDR_W'(UNLOCK_A2);
                cyc_data = DATA_W'(KEY_SECOND);
            end
            3'd2: cyc_data = erase ? DATA_W'(CMD_ESETUP) : DATA_W'(CMD_WORD);
            3'd3: begin
                if (!erase) begin
                    cyc_addr = tgt_addr;
                    cyc_data = tgt_data;
                end
            end
            3'd4: begin
                cyc_addr = ADDR_W'(UNLOCK_A2);
                cyc_data = DATA_W'(KEY_SECOND);
            end
            default: begin
                cyc_addr = tgt_addr;
                cyc_data = DATA_W'(CMD_SECTOR);
            end
        endcase
    end

    // Flag the final cycle of the chosen sequence.
    always_comb cyc_last = erase ? (idx == 3'd5) : (idx == 3'd3);
endmodule

// File: rtl/flash_poll_timer.sv
// Saturating up-counter with a compare: hit is high once count >= limit.
// Counting restarts from zero in any cycle where clr is high.
module flash_poll_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;

    // Count cycles since the last clear, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (!hit)     cnt <= cnt + 1'b1;
    end

    always_comb hit = (cnt >= limit);
endmodule

// File: rtl/flash_prog_engine.sv
// Host-side flash word-write / sector-erase engine. Accepts one request while
// idle, drives the unlock and command writes, polls the toggle bit, verifies the
// result with up to two rereads, and reports done/fail. Assumes read data arrives
// on bus_rdata the cycle after bus_rd, and POLL_GAP >= 1.
module flash_prog_engine
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int POLL_GAP  = 4,
    parameter int PROG_TMO  = 8000,
    parameter int ERASE_TMO = 8000000,
    parameter int STAT_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              fail,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int TMO_MAX = (ERASE_TMO > PROG_TMO) ? ERASE_TMO : PROG_TMO;
    localparam int TMO_W   = $clog2(TMO_MAX + 1);
    localparam int GAP_W   = $clog2(POLL_GAP + 1);

    eng_state_t        state;
    logic [2:0]        idx;
    logic              op_erase;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic              prev_bit;
    logic              have_prev;
    logic              bad_once;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_data;
    logic              seq_last;
    logic              gap_hit;
    logic              tmo_hit;
    logic [DATA_W-1:0] expect_word;
    logic              rd_match;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .idx(idx), .erase(op_erase), .tgt_addr(op_addr), .tgt_data(op_data),
        .cyc_addr(seq_addr), .cyc_data(seq_data), .cyc_last(seq_last)
    );

    flash_poll_timer #(.CNT_W(GAP_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_GAP),
        .limit(GAP_W'(POLL_GAP - 1)), .hit(gap_hit)
    );

    flash_poll_timer #(.CNT_W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
        .limit(op_erase ? TMO_W'(ERASE_TMO) : TMO_W'(PROG_TMO)), .hit(tmo_hit)
    );

    // Expected settled word and comparison against the returned read.
    always_comb begin
        expect_word = op_erase ? '1 : op_data;
        rd_match    = (bus_rdata == expect_word);
    end

    // Bus and handshake outputs decoded from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_wr    = (state == ST_WRITE);
        bus_rd    = (state == ST_POLL_RD) || (state == ST_VER_RD);
        bus_addr  = (state == ST_WRITE) ? seq_addr : op_addr;
        bus_wdata = (state == ST_WRITE) ? seq_data : '0;
    end

    // Main sequencing: command writes, toggle polling, verification, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            op_erase  <= 1'b0;
            op_addr   <= '0;
            op_data   <= '0;
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
            bad_once  <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_erase  <= req_erase;
                        op_addr   <= req_addr;
                        op_data   <= req_data;
                        idx       <= '0;
                        have_prev <= 1'b0;
                        state     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    idx <= idx + 3'd1;
                    if (seq_last) state <= ST_GAP;
                end
                ST_GAP:     if (gap_hit) state <= ST_POLL_RD;
                ST_POLL_RD: state <= ST_POLL_CAP;
                ST_POLL_CAP: begin
                    if (have_prev && (bus_rdata[STAT_BIT] == prev_bit)) begin
                        if (rd_match) begin
                            fail  <= 1'b0;
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            bad_once <= 1'b0;
                            state    <= ST_VER_RD;
                        end
                    end else if (tmo_hit) begin
                        fail  <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        prev_bit  <= bus_rdata[STAT_BIT];
                        have_prev <= 1'b1;
                        state     <= ST_GAP;
                    end
                end
                ST_VER_RD: state <= ST_VER_CAP;
                ST_VER_CAP: begin
                    if (rd_match || bad_once) begin
                        fail  <= !rd_match;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        bad_once <= 1'b1;
                        state    <= ST_VER_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_prog_engine_chk.sv
// Protocol checker for flash_prog_engine, attached by bind below.
module flash_prog_engine_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                                   // R1
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_wr && !bus_rd));                                        // R1
    AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_wr && bus_addr == ADDR_W'(12'h555)
                                      && bus_wdata == DATA_W'(8'hAA)));             // R2
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));                                                       // R4
    AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_rd);                                                        // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                            // R9
    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> req_ready);                                                 // R9
endmodule

bind flash_prog_engine flash_prog_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_flash_prog_engine.sv
module sim_flash_prog_engine;
    localparam int AW = 20, DW = 16, GAP = 4, PTMO = 400, ETMO = 1000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, done, fail, bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    always #2 clk = ~clk;

    flash_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .POLL_GAP(GAP), .PROG_TMO(PTMO),
                        .ERASE_TMO(ETMO), .STAT_BIT(6)) u0 (.*);

    // Flash model knobs: busy reads that toggle, wrong words before settling.
    int m_busy = 0, m_bad = 0;
    logic [DW-1:0] m_good = '0;
    int cyc = 0, wcnt = 0, rd_k = 0, last_wr_cyc = 0, rd0_cyc = 0, rd1_cyc = 0;
    logic [AW-1:0] log_a [8];
    logic [DW-1:0] log_d [8];
    logic [DW-1:0] rdata_q = '0;
    assign bus_rdata = rdata_q;

    function automatic logic [DW-1:0] model_val(int k, int t, int b, logic [DW-1:0] g);
        logic [DW-1:0] v;
        if (k < t) begin
            v = '0; v[7] = ~g[7]; v[6] = ~k[0];
        end else v = ((k - t) < b) ? (g ^ 16'h0001) : g;
        return v;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid && req_ready) begin wcnt <= 0; rd_k <= 0; end
        if (bus_wr) begin
            log_a[wcnt[2:0]] <= bus_addr; log_d[wcnt[2:0]] <= bus_wdata;
            wcnt <= wcnt + 1; last_wr_cyc <= cyc;
        end
        if (bus_rd) begin
            rdata_q <= model_val(rd_k, m_busy, m_bad, m_good);
            if (rd_k == 0) rd0_cyc <= cyc;
            if (rd_k == 1) rd1_cyc <= cyc;
            rd_k <= rd_k + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Expected outcome from R5-R7 given the model knobs.
    function automatic bit predict_fail(int t, int b, logic [DW-1:0] g);
        int k;
        logic p, c;
        logic [DW-1:0] v;
        p = 1'b0;
        for (k = 0; k < t + 4; k++) begin
            v = model_val(k, t, b, g);
            c = v[6];
            if (k > 0 && c == p) break;
            p = c;
        end
        if (!((k - t) < b)) return 1'b0;
        return ((k + 1 - t) < b) && ((k + 2 - t) < b);
    endfunction

    function automatic logic [AW-1:0] exp_addr(bit e, int i, logic [AW-1:0] a);
        if (i == (e ? 5 : 3)) return a;
        return (i == 1 || i == 4) ? AW'(12'h2AA) : AW'(12'h555);
    endfunction

    function automatic logic [DW-1:0] exp_data(bit e, int i, logic [DW-1:0] d);
        if (!e && i == 3) return d;
        if (e && i == 5) return 16'h0050;
        if (i == 1 || i == 4) return 16'h0055;
        if (i == 2) return e ? 16'h0080 : 16'h00A0;
        return 16'h00AA;
    endfunction

    task automatic run_op(bit e, logic [AW-1:0] a, logic [DW-1:0] d, int t, int b,
                          int hold, bit exp_f, bit check_gap);
        int wait_n;
        bit seen;
        m_busy = t; m_bad = b; m_good = e ? '1 : d;
        @(negedge clk);
        req_valid = 1'b1; req_erase = e; req_addr = a; req_data = d;
        @(negedge clk);
        for (int h = 0; h < hold; h++) begin
            req_addr = ~a;
            chk(req_ready == 1'b0, "R1 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        seen = 0;
        for (wait_n = 0; wait_n < 20000 && !seen; wait_n++) begin
            if (done) seen = 1; else @(negedge clk);
        end
        chk(seen, "R9 done pulse", seen, 1);
        chk(req_ready, "R9 ready with done", req_ready, 1);
        chk(fail == exp_f, e ? "R7/R8 erase result" : "R6/R7/R8 write result", fail, exp_f);
        chk(wcnt == (e ? 6 : 4), e ? "R3 write count" : "R2 write count", wcnt, e ? 6 : 4);
        for (int i = 0; i < (e ? 6 : 4); i++) begin
            chk(log_a[i] == exp_addr(e, i, a), e ? "R3 cycle addr" : "R2 cycle addr",
                log_a[i], exp_addr(e, i, a));
            chk(log_d[i] == exp_data(e, i, d), e ? "R3 cycle data" : "R2 cycle data",
                log_d[i], exp_data(e, i, d));
        end
        if (check_gap) begin
            chk(rd0_cyc - last_wr_cyc == GAP + 1, "R4 first read spacing",
                rd0_cyc - last_wr_cyc, GAP + 1);
            chk(rd1_cyc - rd0_cyc == GAP + 2, "R4 poll spacing", rd1_cyc - rd0_cyc, GAP + 2);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        chk(done == 1'b0 && fail == 1'b0, "R10 done/fail in reset", {done, fail}, 0);
        chk(!bus_wr && !bus_rd, "R10 bus idle", {bus_wr, bus_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: clean write, back-pressure held for 8 cycles (R1, R5, R6).
        run_op(1'b0, 20'h12345, 16'hBEEF, 3, 0, 8, 1'b0, 1'b1);
        // R7: one wrong reread rescued; then both rereads wrong.
        run_op(1'b0, 20'h00400, 16'h5A5A, 2, predict_b(2, 16'h5A5A, 0), 0,
               predict_fail(2, predict_b(2, 16'h5A5A, 0), 16'h5A5A), 1'b1);
        run_op(1'b0, 20'h00401, 16'h1234, 2, 6, 0, predict_fail(2, 6, 16'h1234), 1'b1);
        // R8: flash never settles; busy length between the two limits.
        run_op(1'b0, 20'h00010, 16'h0F0F, 1000000, 0, 0, 1'b1, 1'b0);
        run_op(1'b0, 20'h00020, 16'h0F0F, 80, 0, 0, 1'b1, 1'b1);
        run_op(1'b1, 20'h08000, 16'h0000, 80, 0, 0, 1'b0, 1'b1);
        run_op(1'b1, 20'h08800, 16'h0000, 1000000, 0, 0, 1'b1, 1'b0);
        // Random mix (R2, R3, R5, R6, R7).
        for (int n = 0; n < 30; n++) begin
            bit e;
            int t, b;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            e = $urandom % 2; t = $urandom % 12; b = $urandom % 5;
            a = AW'($urandom); d = DW'($urandom);
            run_op(e, a, d, t, b, $urandom % 3, predict_fail(t, b, e ? '1 : d), 1'b1);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Wrong-word count that makes only the first reread wrong (R7 rescue case).
    function automatic int predict_b(int t, logic [DW-1:0] g, int unused);
        int k;
        logic p;
        logic [DW-1:0] v;
        p = 1'b0;
        for (k = 0; k < t + 4; k++) begin
            v = model_val(k, t, 0, g);
            if (k > 0 && v[6] == p) break;
            p = v[6];
        end
        return k - t + 2 + unused;
    endfunction

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL R9 watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule